// File: doc/BRIEF.md
# Lockable Comparator Control Register Bank

This block holds the control words for a pair of comparator channels. Each channel owns one 32-bit word on a simple register bus. The word carries the configuration fields (filter length, hysteresis, output routing, input swap, positive and negative input selects, event selection, speed and single-shot) and one enable bit. The configuration fields drive the comparator logic straight from bus-clock flops.

The enable bit is the only field that crosses into the comparator clock domain. It goes through a toggle handshake with a two-flop synchronizer in each direction. While a change is in flight, the value read back for the enable bit is still the old one, and a status output `sync_busy` stays high. A channel's configuration fields refuse writes while its enable reads one, and while any enable change is in progress. After a zero is written to the enable bit, the fields stay locked until that disable has finished its round trip.

Reserved encodings are stored exactly as written. A per-channel legality flag tells the downstream logic not to treat such a word as a valid mode.

Top module: `ccr_top`

## Requirements
- R1: Channel n's word answers at byte address 0x10 + 4*n (n = 0, 1), and every word resets to zero. Any other address reads zero, and a write to it changes nothing.
- R2: The word has these fields: bits 26:24 filter length, 19 hysteresis, 17:16 output routing, 15 swap, 13:12 positive select, 10:8 negative select, 6:5 event select, 3:2 speed, 1 single-shot and 0 enable. Every other bit reads zero.
- R3: A write updates the non-enable fields only when the channel's enable reads zero and no enable change is pending. Otherwise those fields keep their value.
- R4: `cmp_enable` takes a newly written enable value no earlier than two comparator-clock rising edges after the bus write. It equals the new value by the time `sync_busy` falls, and it never changes while no change is pending.
- R5: While an enable change is pending, the enable bit read on `bus_rdata` keeps its previous value. When the change completes, it shows the new value.
- R6: Writing zero to the enable of an enabled channel leaves the other fields unchanged, even if the same write carries new field values. Those fields stay locked until `sync_busy` has fallen.
- R7: A write whose bit 0 differs from the enable value read back raises `sync_busy` in the next cycle. `sync_busy` falls between 4 and 14 bus cycles later, when the acknowledgement returns.
- R8: A write to a channel while its `sync_busy` is high is ignored completely, including its enable bit.
- R9: Reserved codes are stored and read back verbatim: filter length 3 to 7, output routing 3, speed 2 to 3. `cfg_legal` is 0 for a word that holds any of them and 1 otherwise.
- R10: `cfg_word` for a channel shows that channel's stored fields, with bit 0 forced to zero, from the cycle after the accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| cmp_clk | input | 1 | Comparator digital clock |
| cmp_rst_n | input | 1 | Active-low reset, comparator domain |
| bus_wr | input | 1 | Write strobe for bus_addr / bus_wdata |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sync_busy | output | 2 | Per channel: enable change in flight |
| cmp_enable | output | 2 | Per channel enable, comparator domain |
| cfg_word | output | 64 | Per channel stored fields, 32 bits each, bit 0 zero |
| cfg_legal | output | 2 | Per channel: no reserved code stored |

## Verification
The assertions take three things for granted. The two resets are asserted together. `bus_wdata` and `bus_addr` are steady around each bus-clock rising edge. The enable target, which is a multi-bit crossing in spirit, is only read in the comparator domain after the request toggle has passed its synchronizer. The stimulus drives every input shortly after a bus falling edge and releases both resets together. It uses clock periods that never share an edge, so the handshake latency falls inside the window the reference model accepts. Lock checks come from mixing field writes with enable writes before, during and after each pending change.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int unsigned WORD_W = 32;

    localparam int unsigned EN_BIT     = 0;
    localparam int unsigned FLEN_LO    = 24;
    localparam int unsigned OUTSEL_LO  = 16;
    localparam int unsigned SPEED_LO   = 2;

    localparam logic [WORD_W-1:0] FIELD_MASK = 32'h070B_B76E;
    localparam logic [WORD_W-1:0] READ_MASK  = FIELD_MASK | 32'h1;

    typedef struct packed {
        logic [WORD_W-1:0] cfg;
        logic              en;
        logic              busy;
        logic              req_tog;
        logic              target;
    } bus_chan_t;

    typedef struct packed {
        logic en;
        logic ack_tog;
    } cmp_chan_t;

    function automatic logic word_is_legal(input logic [WORD_W-1:0] w);
        logic [2:0] flen;
        logic [1:0] osel;
        logic [1:0] spd;
        flen = w[FLEN_LO +: 3];
        osel = w[OUTSEL_LO +: 2];
        spd  = w[SPEED_LO +: 2];
        return (flen < 3'd3) && (osel != 2'd3) && (spd < 2'd2);
    endfunction

endpackage

// File: rtl/ccr_sync.sv
module ccr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ccr_chan_bus.sv
module ccr_chan_bus
    import ccr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ack_tog_async,
    output logic              req_tog,
    output logic              target,
    output logic [WORD_W-1:0] cfg,
    output logic              en_rd,
    output logic              busy
);
    bus_chan_t st_d, st_q;
    logic      ack_s;

    ccr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_tog_async),
        .q    (ack_s)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy && (ack_s == st_q.req_tog)) begin
            st_d.busy = 1'b0;
            st_d.en   = st_q.target;
        end
        if (wr_hit && !st_q.busy) begin
            if (!st_q.en) begin
                st_d.cfg = wdata & FIELD_MASK;
            end
            if (wdata[EN_BIT] != st_q.en) begin
                st_d.busy    = 1'b1;
                st_d.req_tog = ~st_q.req_tog;
                st_d.target  = wdata[EN_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tog = st_q.req_tog;
    assign target  = st_q.target;
    assign cfg     = st_q.cfg;
    assign en_rd   = st_q.en;
    assign busy    = st_q.busy;

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en || st_q.busy) |=> $stable(st_q.cfg)); // R3
    AST_DISABLE_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && st_q.en && !st_q.busy && !wdata[EN_BIT]) |=> (st_q.busy && $stable(st_q.cfg))); // R6
    AST_EN_READ_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> $stable(st_q.en)); // R5
    AST_BUSY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !st_q.busy && (wdata[EN_BIT] != st_q.en)) |=> st_q.busy); // R7
    AST_RETRY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && st_q.busy) |=> ($stable(st_q.target) && $stable(st_q.req_tog))); // R8
endmodule

// File: rtl/ccr_chan_cmp.sv
module ccr_chan_cmp
    import ccr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_tog_async,
    input  logic target_async,
    output logic en_out,
    output logic ack_tog
);
    cmp_chan_t st_d, st_q;
    logic      req_s;

    ccr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (req_tog_async),
        .q    (req_s)
    );

    always_comb begin
        st_d = st_q;
        if (req_s != st_q.ack_tog) begin
            st_d.ack_tog = req_s;
            st_d.en      = target_async;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_out  = st_q.en;
    assign ack_tog = st_q.ack_tog;

    AST_CMP_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en != $past(st_q.en)) |-> ($past(req_s) != $past(st_q.ack_tog))); // R4
endmodule

// File: rtl/ccr_top.sv
module ccr_top
    import ccr_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BASE_ADDR   = 16,
    parameter int unsigned STRIDE      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     bus_clk,
    input  logic                     bus_rst_n,
    input  logic                     cmp_clk,
    input  logic                     cmp_rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    output logic [NUM_CH-1:0]        sync_busy,
    output logic [NUM_CH-1:0]        cmp_enable,
    output logic [NUM_CH*WORD_W-1:0] cfg_word,
    output logic [NUM_CH-1:0]        cfg_legal
);
    logic [NUM_CH-1:0]        hit;
    logic [NUM_CH-1:0]        req_tog, target, en_rd, ack_tog;
    logic [WORD_W-1:0]        cfg_arr [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(BASE_ADDR + ch * STRIDE);

        assign hit[ch] = (bus_addr == CH_ADDR);

        ccr_chan_bus #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
            .clk          (bus_clk),
            .rst_n        (bus_rst_n),
            .wr_hit       (bus_wr && hit[ch]),
            .wdata        (bus_wdata),
            .ack_tog_async(ack_tog[ch]),
            .req_tog      (req_tog[ch]),
            .target       (target[ch]),
            .cfg          (cfg_arr[ch]),
            .en_rd        (en_rd[ch]),
            .busy         (sync_busy[ch])
        );

        ccr_chan_cmp #(.SYNC_STAGES(SYNC_STAGES)) u_cmp (
            .clk          (cmp_clk),
            .rst_n        (cmp_rst_n),
            .req_tog_async(req_tog[ch]),
            .target_async (target[ch]),
            .en_out       (cmp_enable[ch]),
            .ack_tog      (ack_tog[ch])
        );

        assign cfg_word[ch*WORD_W +: WORD_W] = cfg_arr[ch];
        assign cfg_legal[ch]                 = word_is_legal(cfg_arr[ch]);
    end

    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (hit[ch]) bus_rdata = bus_rdata | cfg_arr[ch] | WORD_W'(en_rd[ch]);
        end
    end

    always_comb begin
        AST_RSV_READ_ZERO: assert ((bus_rdata & ~READ_MASK) == '0); // R2
    end
endmodule

// File: tb/ccr_top_test.sv
module ccr_top_test;
    localparam int NCH = 2;
    localparam logic [31:0] FMASK = 32'h070B_B76E;

    logic bus_clk = 1'b0;
    logic cmp_clk = 1'b0;
    always #10 bus_clk = ~bus_clk;
    always #13 cmp_clk = ~cmp_clk;

    logic              bus_rst_n, cmp_rst_n, bus_wr;
    logic [7:0]        bus_addr;
    logic [31:0]       bus_wdata, bus_rdata;
    logic [NCH-1:0]    sync_busy, cmp_enable, cfg_legal;
    logic [NCH*32-1:0] cfg_word;

    ccr_top uut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .cmp_clk(cmp_clk), .cmp_rst_n(cmp_rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_busy(sync_busy), .cmp_enable(cmp_enable), .cfg_word(cfg_word), .cfg_legal(cfg_legal)
    );

    logic [31:0] m_cfg  [NCH];
    bit          m_en   [NCH];
    bit          m_busy [NCH];
    bit          m_tgt  [NCH];
    int          m_age  [NCH];
    int          m_ccnt [NCH];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit running = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit legal(input logic [31:0] w);
        return (w[26:24] < 3) && (w[17:16] != 2'd3) && (w[3:2] < 2);
    endfunction

    // Reference model: bus writes, evaluated at the rising edge
    always @(posedge bus_clk) begin
        if (running) begin
            for (int i = 0; i < NCH; i++) if (m_busy[i]) m_age[i]++;
            if (bus_wr) begin
                for (int i = 0; i < NCH; i++) begin
                    if (bus_addr == 8'(16 + 4 * i) && !m_busy[i]) begin
                        if (!m_en[i]) m_cfg[i] = bus_wdata & FMASK;
                        if (bus_wdata[0] != m_en[i]) begin
                            m_busy[i] = 1'b1;
                            m_tgt[i]  = bus_wdata[0];
                            m_age[i]  = 0;
                            m_ccnt[i] = 0;
                        end
                    end
                end
            end
        end
    end

    always @(posedge cmp_clk) begin
        for (int i = 0; i < NCH; i++) if (m_busy[i]) m_ccnt[i]++;
    end

    // Comparison at every falling edge
    always @(negedge bus_clk) begin
        if (running) begin
            logic [31:0] exp_rd;
            cycles++;
            for (int i = 0; i < NCH; i++) begin
                if (m_busy[i] && !sync_busy[i]) begin
                    chk(m_age[i] >= 4 && m_age[i] <= 14, "R7", "busy length", 32'(m_age[i]), 32'd4);
                    chk(cmp_enable[i] == m_tgt[i], "R4", "cmp_enable at completion",
                        32'(cmp_enable[i]), 32'(m_tgt[i]));
                    m_en[i]   = m_tgt[i];
                    m_busy[i] = 1'b0;
                end
                if (m_busy[i] && m_age[i] > 14)
                    chk(1'b0, "R7", "busy stuck", 32'(sync_busy[i]), 32'd0);
                if (m_busy[i] && cmp_enable[i] != m_en[i])
                    chk(m_ccnt[i] >= 2, "R4", "cmp edges before change", 32'(m_ccnt[i]), 32'd2);
                if (!m_busy[i])
                    chk(cmp_enable[i] == m_en[i], "R4", "cmp_enable idle", 32'(cmp_enable[i]), 32'(m_en[i]));
                chk(sync_busy[i] == m_busy[i], "R7", "sync_busy", 32'(sync_busy[i]), 32'(m_busy[i]));
                chk(cfg_word[i*32 +: 32] == m_cfg[i], "R10", "cfg_word", cfg_word[i*32 +: 32], m_cfg[i]);
                chk(cfg_legal[i] == legal(m_cfg[i]), "R9", "cfg_legal", 32'(cfg_legal[i]), 32'(legal(m_cfg[i])));
            end
            exp_rd = '0;
            for (int i = 0; i < NCH; i++)
                if (bus_addr == 8'(16 + 4 * i)) exp_rd = m_cfg[i] | 32'(m_en[i]); // R5: committed enable only
            chk(bus_rdata == exp_rd, "R2", "bus_rdata", bus_rdata, exp_rd);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge bus_clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge bus_clk); #2;
        bus_addr = a;
        @(negedge bus_clk);
    endtask

    task automatic settle();
        for (int k = 0; k < 40; k++) begin
            @(negedge bus_clk);
            if (!m_busy[0] && !m_busy[1]) break;
        end
        @(negedge bus_clk);
    endtask

    initial begin
        #400000;
        chk(1'b0, "R7", "watchdog", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_cfg[i] = '0; m_en[i] = 0; m_busy[i] = 0; m_tgt[i] = 0; m_age[i] = 0; m_ccnt[i] = 0;
        end
        bus_rst_n = 0; cmp_rst_n = 0; bus_wr = 0; bus_addr = 8'h10; bus_wdata = '0;
        repeat (3) @(negedge bus_clk);
        bus_rst_n = 1; cmp_rst_n = 1;
        running = 1'b1;
        // R1: reset values at both channels and an unmapped address
        rd(8'h10); rd(8'h14); rd(8'h00);
        // R2, R10: all-ones pattern lands only on defined fields
        wr(8'h10, 32'hFFFF_FFFE); rd(8'h10);
        // R1: writes to unmapped or misaligned addresses change nothing
        wr(8'h11, 32'h0000_0002); wr(8'h18, 32'h0100_0000); wr(8'h0C, 32'h0); rd(8'h10); rd(8'h18);
        // R9: reserved codes stored verbatim, legality flag drops
        wr(8'h14, 32'h0503_000C); rd(8'h14);
        wr(8'h14, 32'h0102_0004); rd(8'h14);
        // R4, R5, R7: enable channel 0 with a new configuration in the same write
        wr(8'h10, 32'h0208_A561); rd(8'h10);
        // R8: second write while busy, including enable and fields, ignored
        wr(8'h10, 32'h0000_0000); rd(8'h10);
        settle(); rd(8'h10);
        // R3: fields locked while enabled
        wr(8'h10, 32'h0001_0303); rd(8'h10);
        // R6: disable write carrying new fields keeps fields; writes during busy ignored
        wr(8'h10, 32'h0100_0000);
        wr(8'h10, 32'h0200_0000); rd(8'h10);
        settle(); rd(8'h10);
        // R3: unlocked again after the disable completes
        wr(8'h10, 32'h0001_1102); rd(8'h10);
        // R4, R7: both channels in flight together
        wr(8'h10, 32'h0000_0001); wr(8'h14, 32'h0000_0021);
        settle(); rd(8'h14);
        wr(8'h14, 32'h0000_0001); // R7: same value, no handshake
        rd(8'h14);
        wr(8'h10, 32'h0); wr(8'h14, 32'h0);
        settle(); rd(8'h10); rd(8'h14);
        repeat (5) @(negedge bus_clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule